// File: doc/BRIEF.md
# Management Register Access Controller

This block holds a small set of 16-bit management registers behind a plain word-wide read/write port. A serial management frame decoder, or any other agent, drives that port. Every bit carries its own access policy, and each policy is fixed at build time by parameter masks:

- **Fixed** bits return their value on a read and ignore writes.
- **Guarded** bits change only while an arming bit is set.
- **Free** bits are written without condition.
- **Clear-only** bits accept a 0 from a write but never a 1.

All bits return to a parameter default on reset. Selected bits instead take their default from strap inputs, which are latched as reset is released.

The arming bit lives at bit 15 of the register at address 16. It is kept in a two-state machine. In `OVR_LOCKED` the guarded bits ignore writes. A write to address 16 with bit 15 set takes the transition `LOCK_TO_ARM` into `OVR_ARMED`. In `OVR_ARMED` the next write to any implemented address may change the guarded bits, and that write ends the armed period.

A write to another implemented address takes `ARM_TO_LOCK`. A write to address 16 itself takes `ARM_RELOAD` and loads the arming bit from the written bit 15: it stays in `OVR_ARMED` on a 1, or returns to `OVR_LOCKED` on a 0. Reads, and writes to unimplemented addresses, leave the state where it is (`HOLD`). Read data is registered and appears one cycle after the read strobe.

Top module: `mgmt_reg_ctrl`

## Requirements
- R1: After reset every register reads its default. Address 0 reads 16'hA05A, address 16 reads 16'h0300 with bit 15 (the arming bit) at 0.
- R2: Fixed bits ignore writes. In address 1, a write of 16'hFFF0 leaves bits 15:4 at their prior value.
- R3: Free bits take the written value on every write. These are bits 7:0 of addresses 0 and 16, and bits 15:8 and 3:0 of address 17.
- R4: Clear-only bits accept a 0 and ignore a 1. These are bits 3:0 of address 1 and bits 7:4 of address 17.
- R5: While the arming bit is 0, writes leave the guarded bits unchanged. Guarded bits are bits 11:8 of addresses 0 and 16.
- R6: Writing 1 to bit 15 of address 16 lets the next write to another implemented address change its guarded bits. After that write the arming bit reads 0.
- R7: A write to an unimplemented address (implemented addresses are 0, 1, 16 and 17) changes no register and leaves the arming bit as it was.
- R8: Strap-sourced bits hold strap_i as it stood at the last clock edge with reset asserted. These are bits 6:4 of address 1 (from strap_i[6:4]) and bits 3:0 of address 17 (from strap_i[3:0]). Later strap changes do not affect them.
- R9: A read of an unimplemented address returns 0.
- R10: rd_data_o loads the addressed value on the clock edge that samples rd_en_i high, and holds its value on every other edge.
- R11: A write to address 16 while armed may change that register's guarded bits, and sets the arming bit to the written bit 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| strap_i | input | 16 | Strap levels, sampled while reset is asserted |
| rd_data_o | output | 16 | Registered read data |

## Verification
The assertions check the arming machine on every cycle: it stays locked without an arming write, it arms on one, it is released by a write elsewhere, and writes to unimplemented addresses leave it alone. They also check that read data holds between strobes and reads as zero for unimplemented addresses. The per-bit write policies, the strap capture and the reset defaults depend on the register contents, so only the bench scenarios can show them. The bench reads back after chosen write sequences and after a second reset with different strap levels.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    typedef enum logic {
        OVR_LOCKED = 1'b0,
        OVR_ARMED  = 1'b1
    } ovr_state_t;

    // Per-bit write merge; masks are expected to be disjoint, fixed wins.
    function automatic logic [15:0] merge_write(
        input logic [15:0] cur,
        input logic [15:0] wdata,
        input logic [15:0] ro_m,
        input logic [15:0] cw_m,
        input logic [15:0] w0_m,
        input logic        armed
    );
        logic [15:0] rw_m;
        logic [15:0] nxt;
        rw_m = ~(ro_m | cw_m | w0_m);
        nxt  = (cur & ro_m)
             | (wdata & rw_m)
             | ((armed ? wdata : cur) & cw_m & ~ro_m)
             | (cur & wdata & w0_m & ~ro_m);
        return nxt;
    endfunction

endpackage

// File: rtl/mgmt_addr_dec.sv
module mgmt_addr_dec #(
    parameter int ADDR_W = 5,
    parameter int NREG   = 4,
    parameter logic [NREG-1:0][ADDR_W-1:0] REG_ADDR = '0,
    parameter logic [ADDR_W-1:0] OVR_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NREG-1:0]   sel_o,
    output logic              hit_o,
    output logic              is_ovr_o
);
    for (genvar i = 0; i < NREG; i++) begin : g_sel
        assign sel_o[i] = (addr_i == REG_ADDR[i]);
    end

    assign hit_o    = |sel_o;
    assign is_ovr_o = (addr_i == OVR_ADDR);
endmodule

// File: rtl/mgmt_reg_slot.sv
module mgmt_reg_slot #(
    parameter int DATA_W = 16,
    parameter logic [DATA_W-1:0] RO_M  = '0,
    parameter logic [DATA_W-1:0] CW_M  = '0,
    parameter logic [DATA_W-1:0] W0_M  = '0,
    parameter logic [DATA_W-1:0] DEF   = '0,
    parameter logic [DATA_W-1:0] STRAP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              armed_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] strap_i,
    output logic [DATA_W-1:0] q_o
);
    import mgmt_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= (DEF & ~STRAP) | (strap_i & STRAP);
        end else if (wr_en_i) begin
            q_o <= merge_write(q_o, wdata_i, RO_M, CW_M, W0_M, armed_i);
        end
    end
endmodule

// File: rtl/mgmt_reg_ctrl.sv
module mgmt_reg_ctrl #(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int NREG    = 4,
    parameter int OVR_BIT = 15,
    parameter logic [ADDR_W-1:0] OVR_ADDR = 5'd16,
    parameter logic [NREG-1:0][ADDR_W-1:0] REG_ADDR = {5'd17, 5'd16, 5'd1, 5'd0},
    parameter logic [NREG-1:0][DATA_W-1:0] RO_MASK  = {16'h0000, 16'hF000, 16'hFFF0, 16'hF000},
    parameter logic [NREG-1:0][DATA_W-1:0] CW_MASK  = {16'h0000, 16'h0F00, 16'h0000, 16'h0F00},
    parameter logic [NREG-1:0][DATA_W-1:0] W0_MASK  = {16'h00F0, 16'h0000, 16'h000F, 16'h0000},
    parameter logic [NREG-1:0][DATA_W-1:0] DEF_VAL  = {16'h00F0, 16'h0300, 16'h120F, 16'hA05A},
    parameter logic [NREG-1:0][DATA_W-1:0] STRAP_M  = {16'h000F, 16'h0000, 16'h0070, 16'h0000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] strap_i,
    output logic [DATA_W-1:0] rd_data_o
);
    import mgmt_pkg::*;

    localparam logic [DATA_W-1:0] OVR_ONE = DATA_W'(1) << OVR_BIT;

    logic [NREG-1:0]             sel;
    logic                        addr_hit;
    logic                        addr_is_ovr;
    logic                        ovr_armed;
    logic [NREG-1:0][DATA_W-1:0] slot_q;
    logic [DATA_W-1:0]           rd_mux;
    ovr_state_t                  state_q, state_d;

    mgmt_addr_dec #(
        .ADDR_W(ADDR_W), .NREG(NREG), .REG_ADDR(REG_ADDR), .OVR_ADDR(OVR_ADDR)
    ) u_dec (
        .addr_i(addr_i), .sel_o(sel), .hit_o(addr_hit), .is_ovr_o(addr_is_ovr)
    );

    // The arming bit lives in the state machine, so the slot keeps it fixed at 0.
    for (genvar i = 0; i < NREG; i++) begin : g_slot
        localparam logic [DATA_W-1:0] RO_I =
            (REG_ADDR[i] == OVR_ADDR) ? (RO_MASK[i] | OVR_ONE) : RO_MASK[i];
        localparam logic [DATA_W-1:0] DEF_I =
            (REG_ADDR[i] == OVR_ADDR) ? (DEF_VAL[i] & ~OVR_ONE) : DEF_VAL[i];
        mgmt_reg_slot #(
            .DATA_W(DATA_W), .RO_M(RO_I), .CW_M(CW_MASK[i]), .W0_M(W0_MASK[i]),
            .DEF(DEF_I), .STRAP(STRAP_M[i])
        ) u_slot (
            .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i & sel[i]),
            .armed_i(ovr_armed), .wdata_i(wdata_i), .strap_i(strap_i),
            .q_o(slot_q[i])
        );
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OVR_LOCKED;
        else        state_q <= state_d;
    end

    // Transitions: LOCK_TO_ARM, ARM_TO_LOCK, ARM_RELOAD, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVR_LOCKED: begin
                if (wr_en_i && addr_is_ovr && wdata_i[OVR_BIT]) state_d = OVR_ARMED;
            end
            OVR_ARMED: begin
                if (wr_en_i && addr_hit) begin
                    state_d = (addr_is_ovr && wdata_i[OVR_BIT]) ? OVR_ARMED : OVR_LOCKED;
                end
            end
            default: state_d = OVR_LOCKED;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        ovr_armed = (state_q == OVR_ARMED);
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel[i]) rd_mux = rd_mux | slot_q[i];
        end
        if (addr_is_ovr && ovr_armed) rd_mux = rd_mux | OVR_ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data_o <= '0;
        else if (rd_en_i) rd_data_o <= rd_mux;
    end
endmodule

// File: rtl/mgmt_reg_ctrl_chk.sv
module mgmt_reg_ctrl_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              hit,
    input logic              is_ovr,
    input logic              ovr_set,
    input logic              armed,
    input logic [DATA_W-1:0] rd_data
);
    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !(wr_en && is_ovr)) |=> !armed); // R5

    AST_ARM_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_ovr && ovr_set) |=> armed); // R11

    AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_en && hit && !is_ovr) |=> !armed); // R6

    AST_UNIMPL_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> $stable(armed)); // R7

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R10

    AST_UNIMPL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> (rd_data == '0)); // R9
endmodule

bind mgmt_reg_ctrl mgmt_reg_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .rd_en(rd_en_i),
    .hit(addr_hit), .is_ovr(addr_is_ovr), .ovr_set(wdata_i[OVR_BIT]),
    .armed(ovr_armed), .rd_data(rd_data_o)
);

// File: tb/mgmt_reg_ctrl_bench.sv
`timescale 1ns/1ps
module mgmt_reg_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] strap = 16'h0035;
    logic [15:0] rd_data;
    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    mgmt_reg_ctrl u_mgmt_reg_ctrl (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .strap_i(strap), .rd_data_o(rd_data)
    );

    typedef struct packed {
        logic        is_wr;
        logic [4:0]  a;
        logic [15:0] d;   // write data, or expected read value
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 5'd0,  16'hA05A, 4'd1},  // R1 default
        '{1'b0, 5'd16, 16'h0300, 4'd1},  // R1 arming bit clear
        '{1'b0, 5'd1,  16'h123F, 4'd8},  // R8 strap 6:4 = 3
        '{1'b0, 5'd17, 16'h00F5, 4'd8},  // R8 strap 3:0 = 5
        '{1'b1, 5'd0,  16'hFFFF, 4'd3},
        '{1'b0, 5'd0,  16'hA0FF, 4'd3},  // R3 free byte set, guarded blocked
        '{1'b1, 5'd1,  16'h0005, 4'd4},
        '{1'b0, 5'd1,  16'h1235, 4'd4},  // R4 clear-only cleared
        '{1'b1, 5'd1,  16'h000F, 4'd4},
        '{1'b0, 5'd1,  16'h1235, 4'd4},  // R4 ones ignored
        '{1'b1, 5'd1,  16'hFFF0, 4'd2},
        '{1'b0, 5'd1,  16'h1230, 4'd2},  // R2 fixed bits unchanged
        '{1'b1, 5'd16, 16'h8000, 4'd6},
        '{1'b0, 5'd16, 16'h8300, 4'd6},  // R6 armed
        '{1'b1, 5'd5,  16'hFFFF, 4'd7},
        '{1'b0, 5'd16, 16'h8300, 4'd7},  // R7 still armed
        '{1'b0, 5'd5,  16'h0000, 4'd9},  // R9 unimplemented reads 0
        '{1'b1, 5'd0,  16'h0C00, 4'd6},
        '{1'b0, 5'd0,  16'hAC00, 4'd6},  // R6 guarded changed
        '{1'b0, 5'd16, 16'h0300, 4'd6},  // R6 arming self-cleared
        '{1'b1, 5'd0,  16'h0300, 4'd5},
        '{1'b0, 5'd0,  16'hAC00, 4'd5},  // R5 guarded blocked again
        '{1'b1, 5'd16, 16'h8000, 4'd11},
        '{1'b1, 5'd16, 16'h8512, 4'd11},
        '{1'b0, 5'd16, 16'h8512, 4'd11}, // R11 guarded in 16, re-armed
        '{1'b1, 5'd17, 16'hFF0A, 4'd3},
        '{1'b0, 5'd17, 16'hFF0A, 4'd3},  // R3 and R4 in address 17
        '{1'b0, 5'd16, 16'h0512, 4'd6},  // R6 released by write to 17
        '{1'b1, 5'd16, 16'h8000, 4'd11},
        '{1'b1, 5'd16, 16'h0000, 4'd11},
        '{1'b0, 5'd16, 16'h0000, 4'd11}  // R11 armed write of 0 disarms
    };

    task automatic check(input int req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL R%0d got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic do_wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [4:0] a, output logic [15:0] got);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        got = rd_data;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] got;
        repeat (3) @(negedge clk);
        check(10, rd_data, 16'h0000);   // R10 reset value of read port
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        strap = 16'h004A;               // later strap change must not matter (R8)

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_wr) do_wr(VEC[i].a, VEC[i].d);
            else begin
                do_rd(VEC[i].a, got);
                check(int'(VEC[i].req), got, VEC[i].d);
            end
        end

        // R10: read data holds while no read strobe
        do_rd(5'd0, got);
        check(10, got, 16'hAC00);
        do_wr(5'd0, 16'h00FF);
        @(negedge clk);
        check(10, rd_data, 16'hAC00);
        do_rd(5'd0, got);
        check(10, got, 16'hACFF);

        // R1 and R8: second reset with new strap levels
        @(negedge clk);
        strap = 16'h0000;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        strap = 16'hFFFF;
        do_rd(5'd0, got);  check(1, got, 16'hA05A);
        do_rd(5'd16, got); check(1, got, 16'h0300);
        do_rd(5'd1, got);  check(8, got, 16'h120F);
        do_rd(5'd17, got); check(8, got, 16'h00F0);

        finish_run();
    end
endmodule